// File: doc/BRIEF.md
# Index Step-and-Test Unit

This unit executes the two index-stepping instructions of a 16-bit processor: one increments the index register X, the other decrements it. The low byte of the instruction word is an unsigned step size. The increment form adds it to X as a positive amount. The decrement form adds it as its negative. The sum is formed over all 16 bits in two's complement.

The sign test uses only the 15-bit field below the top bit of X. The increment form requests a skip of the next instruction when that field moves from negative to positive. The decrement form requests a skip when the field moves from positive to negative. The top bit of X doubles as the post-index indirect flag. Because the add spans all 16 bits, the carry or borrow that crosses the field boundary toggles that flag whenever a skip occurs.

The surrounding pipeline presents the instruction word, a valid strobe and the current X. One clock later the unit returns the updated X, a result strobe and the skip request. Words with any other opcode are ignored. The condition code is never touched.

Top module: `idx_step_unit`

## Requirements
- R1: During and straight after reset, `res_valid` and `skip` are 0 and `x_next` is 0.
- R2: When `instr_valid` is 1 and `instr[15:8]` is 8'h24 (increment), `x_next` equals (`x_in` + `instr[7:0]`) mod 65536 on the following cycle.
- R3: When `instr_valid` is 1 and `instr[15:8]` is 8'h25 (decrement), `x_next` equals (`x_in` - `instr[7:0]`) mod 65536 on the following cycle.
- R4: For an increment, `skip` is 1 on the following cycle exactly when `x_in[14:0]` + step exceeds 15'h7FFF. This is when bit 14 goes from 1 to 0.
- R5: For a decrement, `skip` is 1 on the following cycle exactly when `x_in[14:0]` is below the step. This is when bit 14 goes from 0 to 1.
- R6: For every accepted step, `x_next[15]` differs from the prior `x_in[15]` exactly when `skip` is 1.
- R7: A step field of zero leaves `x_next` equal to `x_in` and never skips, for either opcode.
- R8: A cycle with `instr_valid` at 0, or with `instr[15:8]` other than 8'h24 or 8'h25, gives `res_valid` 0 and `skip` 0 on the next cycle and leaves `x_next` unchanged.
- R9: `res_valid` is 1 exactly in the cycle after an accepted step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| instr_valid | input | 1 | Instruction word is present this cycle |
| instr | input | 16 | Instruction word; [15:8] opcode, [7:0] step size |
| x_in | input | 16 | Current index register value |
| res_valid | output | 1 | `x_next` and `skip` belong to the step accepted last cycle |
| x_next | output | 16 | Updated index register value |
| skip | output | 1 | Skip of the next instruction requested |

## Verification
A wrong step extension or a broken carry chain shows up in `x_next` in the cycle right after the step. A wrong sign-crossing decision shows up in `skip` in that same cycle, and so does a mismatch between the skip and the toggled top bit. Small steps at the crossing points expose an off-by-one test that wide steps would hide. A decode fault becomes visible as a missing or spurious `res_valid` one cycle after the word, or as an `x_next` that changes on an ignored word.

// File: rtl/idx_step_pkg.sv
package idx_step_pkg;

  // Kind of step selected by the opcode byte.
  typedef enum logic [1:0] {
    STEP_NONE = 2'd0,
    STEP_INC  = 2'd1,
    STEP_DEC  = 2'd2
  } step_op_e;

  // Skip rule: increment looks for negative-to-positive,
  // decrement looks for positive-to-negative on the field sign.
  function automatic logic crossed_sign(step_op_e op, logic old_sgn, logic new_sgn);
    logic r;
    unique case (op)
      STEP_INC: r = old_sgn & ~new_sgn;
      STEP_DEC: r = ~old_sgn & new_sgn;
      default:  r = 1'b0;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/idx_step_decode.sv
module idx_step_decode
  import idx_step_pkg::*;
#(
  parameter int            XW       = 16,
  parameter int            MW       = 8,
  parameter logic [XW-MW-1:0] INC_CODE = 8'h24,
  parameter logic [XW-MW-1:0] DEC_CODE = 8'h25
) (
  input  logic          valid,
  input  logic [XW-1:0] word,
  output step_op_e      op,
  output logic [MW-1:0] mag
);
  localparam int OPW = XW - MW;

  logic [OPW-1:0] opc;

  assign opc = word[XW-1:MW];
  assign mag = word[MW-1:0];

  always_comb begin
    op = STEP_NONE;
    if (valid) begin
      if (opc == INC_CODE)      op = STEP_INC;
      else if (opc == DEC_CODE) op = STEP_DEC;
    end
  end
endmodule

// File: rtl/idx_step_addend.sv
module idx_step_addend
  import idx_step_pkg::*;
#(
  parameter int XW = 16,
  parameter int MW = 8
) (
  input  step_op_e      op,
  input  logic [MW-1:0] mag,
  output logic [XW-1:0] addend
);
  // Zero-extend the step, then negate it for the decrement form.
  function automatic logic [XW-1:0] extend_step(logic [MW-1:0] m, logic neg);
    logic [XW-1:0] z;
    z = {{(XW-MW){1'b0}}, m};
    return neg ? (~z + {{(XW-1){1'b0}}, 1'b1}) : z;
  endfunction

  assign addend = extend_step(mag, op == STEP_DEC);
endmodule

// File: rtl/idx_step_adder.sv
module idx_step_adder #(
  parameter int XW = 16
) (
  input  logic [XW-1:0] a,
  input  logic [XW-1:0] b,
  output logic [XW-1:0] sum
);
  // Full-width add; the carry out of the top bit is dropped.
  function automatic logic [XW-1:0] wrap_add(logic [XW-1:0] p, logic [XW-1:0] q);
    logic [XW:0] t;
    t = {1'b0, p} + {1'b0, q};
    return t[XW-1:0];
  endfunction

  assign sum = wrap_add(a, b);
endmodule

// File: rtl/idx_step_skip.sv
module idx_step_skip
  import idx_step_pkg::*;
(
  input  step_op_e op,
  input  logic     old_sgn,
  input  logic     new_sgn,
  output logic     skip_req
);
  assign skip_req = crossed_sign(op, old_sgn, new_sgn);
endmodule

// File: rtl/idx_step_unit.sv
module idx_step_unit
  import idx_step_pkg::*;
#(
  parameter int               XW       = 16,
  parameter int               MW       = 8,
  parameter logic [XW-MW-1:0] INC_CODE = 8'h24,
  parameter logic [XW-MW-1:0] DEC_CODE = 8'h25
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          instr_valid,
  input  logic [XW-1:0] instr,
  input  logic [XW-1:0] x_in,
  output logic          res_valid,
  output logic [XW-1:0] x_next,
  output logic          skip
);
  localparam int SGN = XW - 2;  // sign bit of the tested field
  localparam int TOP = XW - 1;  // post-index indirect flag

  step_op_e      op;
  logic [MW-1:0] mag;
  logic [XW-1:0] addend;
  logic [XW-1:0] sum;
  logic          skip_now;
  logic          accept;
  logic          top_flip;

  idx_step_decode #(
    .XW(XW), .MW(MW), .INC_CODE(INC_CODE), .DEC_CODE(DEC_CODE)
  ) u_dec (
    .valid(instr_valid), .word(instr), .op(op), .mag(mag)
  );

  idx_step_addend #(.XW(XW), .MW(MW)) u_ext (
    .op(op), .mag(mag), .addend(addend)
  );

  idx_step_adder #(.XW(XW)) u_add (
    .a(x_in), .b(addend), .sum(sum)
  );

  idx_step_skip u_skp (
    .op(op), .old_sgn(x_in[SGN]), .new_sgn(sum[SGN]), .skip_req(skip_now)
  );

  // Named internal events for the checker.
  assign accept   = (op != STEP_NONE);
  assign top_flip = sum[TOP] ^ x_in[TOP];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      res_valid <= 1'b0;
      skip      <= 1'b0;
      x_next    <= '0;
    end else begin
      res_valid <= accept;
      skip      <= accept & skip_now;
      if (accept) x_next <= sum;
    end
  end
endmodule

// File: rtl/idx_step_unit_chk.sv
module idx_step_unit_chk #(
  parameter int               XW       = 16,
  parameter int               MW       = 8,
  parameter logic [XW-MW-1:0] INC_CODE = 8'h24,
  parameter logic [XW-MW-1:0] DEC_CODE = 8'h25
) (
  input logic          clk,
  input logic          rst_n,
  input logic          instr_valid,
  input logic [XW-1:0] instr,
  input logic [XW-1:0] x_in,
  input logic          res_valid,
  input logic [XW-1:0] x_next,
  input logic          skip,
  input logic          accept,
  input logic          top_flip,
  input logic          skip_now
);
  logic is_inc, is_dec, taken, zero_mag;
  assign is_inc   = instr_valid && (instr[XW-1:MW] == INC_CODE);
  assign is_dec   = instr_valid && (instr[XW-1:MW] == DEC_CODE);
  assign taken    = is_inc || is_dec;
  assign zero_mag = (instr[MW-1:0] == '0);

  p_reset_quiet_r1: assert property (@(posedge clk)
    !rst_n |=> (!res_valid && !skip && x_next == '0));

  p_result_strobe_r9: assert property (@(posedge clk) disable iff (!rst_n)
    taken |=> res_valid);

  p_ignored_word_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !taken |=> (!res_valid && !skip && $stable(x_next)));

  p_inc_skip_r4: assert property (@(posedge clk) disable iff (!rst_n)
    is_inc |=> (skip == ($past(x_in[XW-2]) && !x_next[XW-2])));

  p_dec_skip_r5: assert property (@(posedge clk) disable iff (!rst_n)
    is_dec |=> (skip == (!$past(x_in[XW-2]) && x_next[XW-2])));

  p_flip_tracks_skip_r6: assert property (@(posedge clk) disable iff (!rst_n)
    accept |-> (top_flip == skip_now));

  p_zero_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (taken && zero_mag) |=> (x_next == $past(x_in) && !skip));
endmodule

bind idx_step_unit idx_step_unit_chk #(
  .XW(XW), .MW(MW), .INC_CODE(INC_CODE), .DEC_CODE(DEC_CODE)
) u_chk (
  .clk(clk), .rst_n(rst_n), .instr_valid(instr_valid), .instr(instr),
  .x_in(x_in), .res_valid(res_valid), .x_next(x_next), .skip(skip),
  .accept(accept), .top_flip(top_flip), .skip_now(skip_now)
);

// File: tb/idx_step_unit_tb.sv
module idx_step_unit_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        instr_valid = 1'b0;
  logic [15:0] instr = '0;
  logic [15:0] x_in = '0;
  logic        res_valid;
  logic [15:0] x_next;
  logic        skip;

  int checks = 0;
  int failures = 0;
  int cycles = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  idx_step_unit u_dut (
    .clk(clk), .rst_n(rst_n), .instr_valid(instr_valid), .instr(instr),
    .x_in(x_in), .res_valid(res_valid), .x_next(x_next), .skip(skip)
  );

  task automatic check(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Apply one step word, then check outputs at the next falling edge.
  task automatic step(bit inc, int m, int x);
    int ex, es;
    instr_valid = 1'b1;
    instr = {inc ? 8'h24 : 8'h25, 8'(m)};
    x_in  = 16'(x);
    @(negedge clk);
    if (inc) begin
      ex = (x + m) & 32'hFFFF;
      es = (((x & 32'h7FFF) + m) > 32'h7FFF) ? 1 : 0;
    end else begin
      ex = (x - m + 65536) & 32'hFFFF;
      es = ((x & 32'h7FFF) < m) ? 1 : 0;
    end
    check(res_valid === 1'b1, "R9 res_valid", int'(res_valid), 1);
    check(int'(x_next) == ex, inc ? "R2 inc x" : "R3 dec x", int'(x_next), ex);
    check(int'(skip) == es, inc ? "R4 inc skip" : "R5 dec skip", int'(skip), es);
    check((x_next[15] != x[15]) == skip, "R6 flag toggle", int'(x_next[15]), x[15]);
    if (m == 0)
      check(int'(x_next) == x && !skip, "R7 zero step", int'(x_next), x);
  endtask

  initial begin
    int xs[16] = '{16'h0000, 16'h0001, 16'h00FF, 16'h3FFF, 16'h4000, 16'h7F00,
                   16'h7FFF, 16'h8000, 16'h8001, 16'hBFFF, 16'hC000, 16'hFFFF,
                   16'hFF80, 16'h7FF0, 16'h1234, 16'hA5A5};
    repeat (3) @(negedge clk);
    check(!res_valid && !skip && x_next == 16'h0, "R1 reset",
          int'({res_valid, skip, x_next}), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(!res_valid && !skip && x_next == 16'h0, "R1 after reset",
          int'({res_valid, skip, x_next}), 0);

    // Sweep every step size over chosen X values.
    foreach (xs[i])
      for (int m = 0; m < 256; m++) begin
        step(1'b1, m, xs[i]);
        step(1'b0, m, xs[i]);
      end

    // Dense sweep around the two field sign boundaries.
    for (int k = -512; k < 512; k++) begin
      step(1'b1, 1,   (32'h8000 + k) & 32'hFFFF);
      step(1'b0, 1,   (32'h8000 + k) & 32'hFFFF);
      step(1'b1, 255, (65536 + k) & 32'hFFFF);
      step(1'b0, 255, (65536 + k) & 32'hFFFF);
    end

    // Ignored words: foreign opcodes and invalid cycles.
    for (int h = 0; h < 256; h++) begin
      step(1'b1, 3, 16'h7FFE);  // known result 16'h8001, skip 1
      instr_valid = (h != 8'h24 && h != 8'h25);
      instr = {8'(h), 8'h11};
      x_in  = 16'h0000;
      @(negedge clk);
      check(!res_valid, "R8 no strobe", int'(res_valid), 0);
      check(!skip, "R8 no skip", int'(skip), 0);
      check(x_next == 16'h8001, "R8 x held", int'(x_next), 16'h8001);
    end
    instr_valid = 1'b0;
    @(negedge clk);
    check(!res_valid, "R9 strobe drops", int'(res_valid), 0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 190000 && !done) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule